// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of thirteen general-purpose pins controlled through a simple register bus. The bus has one address, one write strobe, write data and a read path that responds in the same cycle. Each pin has two byte-wide control registers. The drive register sets direction, driver style, pull resistor and the value driven. The sense register returns the synchronised pin level and selects which edges raise an event. The block drives the pad output enable, the output data and three pull controls for each pin.

Edge events set per-pin pending bits. These bits sit in two status registers: a low group of seven pins and a high group of six pins. Each status register has a mask register beside it. A single level interrupt goes to the host and stays asserted while any unmasked pending bit is set. The host reads the status, services the pins, and writes the same value back to clear what it has handled.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset:
  - every drive register reads 0 and every sense register reads 0 (edge select off, pads held low);
  - both status registers read 0;
  - the masks read 0x7F (low group) and 0x3F (high group);
  - pad_oe, pull_en and irq are 0.
- R2: The drive register of pin p is at address 0x00+p and stores bits 5:0:
  - bit 5 is direction (1 = output);
  - bit 4 is driver style (1 = push-pull, 0 = open-drain);
  - bit 3 is pull enable;
  - bits 2:1 are the pull code;
  - bit 0 is the output value;
  - bits 7:6 read as 0.
- R3: pad_out always equals drive bit 0. In push-pull style, pad_oe equals the direction bit. In open-drain style, pad_oe is 1 only when the direction is output and the value is 0.
- R4: pull_en follows drive bit 3. The pull code (bits 2:1) maps as follows: 00 is a 2k pull-down, 01 a 2k pull-up, 10 a 50k pull-down and 11 a 50k pull-up. pull_up is 1 for the up codes. pull_strong is 1 for the 2k codes.
- R5: The sense register of pin p is at address 0x10+p. Its bit 0 returns the pad level through a two-flop synchroniser, so a pad change becomes visible after the second rising clock edge.
- R6: Sense bits 2:1 select edge detection: 00 off, 01 falling, 10 rising, 11 both. A selected edge sets the pin's status bit on the third rising edge after the pad change. An unselected edge sets nothing.
- R7: Status registers are at 0x20 (pins 0 to 6 in bits 0 to 6) and 0x21 (pins 7 to 12 in bits 0 to 5). Masks are at 0x24 and 0x25 with the same bit layout. Bits beyond a group's width read 0.
- R8: A selected edge sets its status bit whatever the mask. A mask bit of 1 keeps that pin out of irq.
- R9: irq is high exactly while some status bit with a mask bit of 0 is set, and it stays high until that bit is cleared or masked.
- R10: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R11: If an edge event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R12: Writes to a sense register change only bits 2:1. Bit 0 always shows the pad level, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| pad_in | input | 13 | Pad input levels, asynchronous |
| pad_oe | output | 13 | Pad output enable per pin |
| pad_out | output | 13 | Pad output data per pin |
| pull_en | output | 13 | Pull resistor enable per pin |
| pull_up | output | 13 | Pull direction per pin (1 = up) |
| pull_strong | output | 13 | Pull strength per pin (1 = 2k, 0 = 50k) |
| irq | output | 1 | Level interrupt to the host |

## Verification
Each result of this block arrives at a fixed delay after its stimulus:
- A register write shows on the read port and on the pad and pull outputs at the first falling edge after the writing clock edge.
- The level readback is due two rising edges after a pad change, and a pending bit three rising edges after it.
- irq follows the status and mask registers within the same cycle.

The bench changes pads and bus signals on falling edges and counts rising edges explicitly before sampling. Where a result is due on the third edge, it also samples after the second edge to confirm the result has not arrived early. The same-cycle set-over-clear case is built by placing the clearing write exactly on the edge where the event is captured.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // drive register field positions
   localparam int unsigned CTRL_W   = 6;
   localparam int unsigned DRV_DIR  = 5;
   localparam int unsigned DRV_PP   = 4;
   localparam int unsigned DRV_PEN  = 3;
   localparam int unsigned DRV_PHI  = 2;
   localparam int unsigned DRV_PLO  = 1;
   localparam int unsigned DRV_VAL  = 0;
   localparam int unsigned SENSE_W  = 3;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_edge_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                drv_we,
   input  logic                sense_we,
   input  logic [CTRL_W-1:0]   wdata,
   input  logic                pad_in,
   output logic [CTRL_W-1:0]   drv_rd,
   output logic [SENSE_W-1:0]  sense_rd,
   output logic                pad_oe,
   output logic                pad_out,
   output logic                pull_en,
   output logic                pull_up,
   output logic                pull_strong,
   output logic                edge_evt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_pin_cell: SYNC_STAGES must be at least 2");
   end

   logic [CTRL_W-1:0]      drv_q;
   edge_sel_e              sel_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   level;
   logic                   rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q  <= '0;
         sel_q  <= EDGE_OFF;
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         if (drv_we)   drv_q <= wdata;
         if (sense_we) sel_q <= edge_sel_e'(wdata[2:1]);
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
         prev_q <= level;
      end
   end

   assign level    = sync_q[SYNC_STAGES-1];
   assign rise     = level & ~prev_q;
   assign fall     = ~level & prev_q;
   assign edge_evt = (sel_q[1] & rise) | (sel_q[0] & fall);

   assign pad_out     = drv_q[DRV_VAL];
   assign pad_oe      = drv_q[DRV_DIR] & (drv_q[DRV_PP] | ~drv_q[DRV_VAL]);
   assign pull_en     = drv_q[DRV_PEN];
   assign pull_up     = drv_q[DRV_PLO];
   assign pull_strong = ~drv_q[DRV_PHI];

   assign drv_rd   = drv_q;
   assign sense_rd = {sel_q, level};

   // R3
   od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe && !drv_q[DRV_PP]) |-> !pad_out);

   // R6
   edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == EDGE_OFF) |-> !edge_evt);
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         st_we,
   input  logic         mk_we,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] status,
   output logic [N-1:0] mask,
   output logic         irq_req
);
   if (N < 1) begin : g_bad_width
      $error("gpio_irq_group: N must be at least 1");
   end

   logic [N-1:0] clr;

   assign clr = st_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         status <= (status & ~clr) | evt;
         if (mk_we) mask <= wdata;
      end
   end

   assign irq_req = |(status & ~mask);

   // R8
   evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

   // R10
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |=> ((status & $past(wdata & ~evt)) == '0));

   // R9
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !st_we && !mk_we) |=> irq_req);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 13,
   parameter int unsigned GRP0_PINS   = 7,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DRV_BASE    = 'h00,
   parameter int unsigned SENSE_BASE  = 'h10,
   parameter int unsigned ST_BASE     = 'h20,
   parameter int unsigned MK_BASE     = 'h24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wen,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pull_en,
   output logic [NUM_PINS-1:0] pull_up,
   output logic [NUM_PINS-1:0] pull_strong,
   output logic                irq
);
   localparam int unsigned GRP1_PINS = NUM_PINS - GRP0_PINS;

   if (GRP0_PINS < 1 || GRP0_PINS >= NUM_PINS) begin : g_bad_split
      $error("gpio_edge_bank: GRP0_PINS must leave both groups non-empty");
   end
   if (GRP0_PINS > DATA_W || GRP1_PINS > DATA_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("gpio_edge_bank: DATA_W too narrow for groups or control fields");
   end
   if (SENSE_BASE < DRV_BASE + NUM_PINS) begin : g_bad_map
      $error("gpio_edge_bank: sense array overlaps drive array");
   end

   logic [NUM_PINS-1:0] evt_all;
   logic [CTRL_W-1:0]   drv_rd   [NUM_PINS];
   logic [SENSE_W-1:0]  sense_rd [NUM_PINS];
   logic [GRP0_PINS-1:0] st0, mk0;
   logic [GRP1_PINS-1:0] st1, mk1;
   logic irq0, irq1;
   logic unused_bus;

   assign unused_bus = ^bus_wdata;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic drv_we, sense_we;
      assign drv_we   = bus_wen && (bus_addr == ADDR_W'(DRV_BASE + p));
      assign sense_we = bus_wen && (bus_addr == ADDR_W'(SENSE_BASE + p));

      gpio_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .drv_we      (drv_we),
         .sense_we    (sense_we),
         .wdata       (bus_wdata[CTRL_W-1:0]),
         .pad_in      (pad_in[p]),
         .drv_rd      (drv_rd[p]),
         .sense_rd    (sense_rd[p]),
         .pad_oe      (pad_oe[p]),
         .pad_out     (pad_out[p]),
         .pull_en     (pull_en[p]),
         .pull_up     (pull_up[p]),
         .pull_strong (pull_strong[p]),
         .edge_evt    (evt_all[p])
      );
   end

   gpio_irq_group #(.N(GRP0_PINS)) u_grp0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_all[GRP0_PINS-1:0]),
      .st_we   (bus_wen && bus_addr == ADDR_W'(ST_BASE)),
      .mk_we   (bus_wen && bus_addr == ADDR_W'(MK_BASE)),
      .wdata   (bus_wdata[GRP0_PINS-1:0]),
      .status  (st0),
      .mask    (mk0),
      .irq_req (irq0)
   );

   gpio_irq_group #(.N(GRP1_PINS)) u_grp1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_all[NUM_PINS-1:GRP0_PINS]),
      .st_we   (bus_wen && bus_addr == ADDR_W'(ST_BASE + 1)),
      .mk_we   (bus_wen && bus_addr == ADDR_W'(MK_BASE + 1)),
      .wdata   (bus_wdata[GRP1_PINS-1:0]),
      .status  (st1),
      .mask    (mk1),
      .irq_req (irq1)
   );

   assign irq = irq0 | irq1;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (bus_addr == ADDR_W'(DRV_BASE + i))   bus_rdata = DATA_W'(drv_rd[i]);
         if (bus_addr == ADDR_W'(SENSE_BASE + i)) bus_rdata = DATA_W'(sense_rd[i]);
      end
      if (bus_addr == ADDR_W'(ST_BASE))     bus_rdata = DATA_W'(st0);
      if (bus_addr == ADDR_W'(ST_BASE + 1)) bus_rdata = DATA_W'(st1);
      if (bus_addr == ADDR_W'(MK_BASE))     bus_rdata = DATA_W'(mk0);
      if (bus_addr == ADDR_W'(MK_BASE + 1)) bus_rdata = DATA_W'(mk1);
   end

   // R1
   irq_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [12:0] pad_in = '0;
   logic [12:0] pad_oe, pad_out, pull_en, pull_up, pull_strong;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_edge_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pull_en(pull_en),
      .pull_up(pull_up), .pull_strong(pull_strong), .irq(irq)
   );

   // {pin[3:0], wdata[7:0], exp oe, out, pull_en, pull_up, pull_strong}
   localparam logic [16:0] VEC [10] = '{
      {4'd0,  8'h00, 5'b00001},
      {4'd1,  8'h31, 5'b11001},
      {4'd2,  8'h30, 5'b10001},
      {4'd3,  8'h21, 5'b01001},
      {4'd4,  8'h20, 5'b10001},
      {4'd5,  8'h0A, 5'b00111},
      {4'd6,  8'h0C, 5'b00100},
      {4'd12, 8'h0F, 5'b01110},
      {4'd7,  8'hF1, 5'b11001},
      {4'd10, 8'h10, 5'b00001}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int p = 0; p < 13; p++) begin
         peek(8'(p), rd);        check("R1 drive reg", rd, 8'h00);
         peek(8'(8'h10 + p), rd); check("R1 sense reg", rd, 8'h00);
      end
      peek(8'h20, rd); check("R1 status0", rd, 8'h00);
      peek(8'h21, rd); check("R1 status1", rd, 8'h00);
      peek(8'h24, rd); check("R1 mask0", rd, 8'h7F);
      peek(8'h25, rd); check("R1 mask1", rd, 8'h3F);
      check("R1 pad_oe", pad_oe, 13'h0);
      check("R1 pull_en", pull_en, 13'h0);
      check("R1 irq", irq, 1'b0);

      // R2 R3 R4 vector walk over drive register codes
      for (int k = 0; k < 10; k++) begin
         logic [3:0] pin;
         logic [7:0] wd;
         logic [4:0] ex;
         {pin, wd, ex} = VEC[k];
         bus_write(8'(pin), wd);
         peek(8'(pin), rd);
         check("R2 drive readback", rd, wd & 8'h3F);
         check("R3 pad_oe", pad_oe[pin], ex[4]);
         check("R3 pad_out", pad_out[pin], ex[3]);
         check("R4 pull_en", pull_en[pin], ex[2]);
         check("R4 pull_up", pull_up[pin], ex[1]);
         check("R4 pull_strong", pull_strong[pin], ex[0]);
      end

      // R7 mask width
      bus_write(8'h24, 8'hFF);
      peek(8'h24, rd); check("R7 mask0 width", rd, 8'h7F);
      bus_write(8'h25, 8'hFF);
      peek(8'h25, rd); check("R7 mask1 width", rd, 8'h3F);

      // R5 synchroniser latency on pin 8, edge select off
      bus_addr = 8'h18;
      @(negedge clk); pad_in[8] = 1'b1;
      wait_edges(1);
      peek(8'h18, rd); check("R5 level after one edge", rd, 8'h00);
      wait_edges(1);
      peek(8'h18, rd); check("R5 level after two edges", rd, 8'h01);
      wait_edges(3);
      peek(8'h21, rd); check("R6 edge off sets nothing", rd, 8'h00);

      // R12 only bits 2:1 of sense register writable
      bus_write(8'h18, 8'hF8);
      peek(8'h18, rd); check("R12 sense write ignore", rd, 8'h01);
      bus_write(8'h18, 8'h00);

      // R6 R8 rising edge on pin 2, masked
      bus_write(8'h12, 8'h04);
      @(negedge clk); pad_in[2] = 1'b1;
      wait_edges(2);
      peek(8'h20, rd); check("R6 status not yet set", rd, 8'h00);
      wait_edges(1);
      peek(8'h20, rd); check("R6 rising edge on third edge", rd, 8'h04);
      check("R8 masked keeps irq low", irq, 1'b0);
      bus_write(8'h24, 8'h7B);
      check("R9 unmask raises irq", irq, 1'b1);
      @(negedge clk); pad_in[2] = 1'b0;
      wait_edges(4);
      peek(8'h20, rd); check("R6 falling ignored for rise select", rd, 8'h04);
      check("R9 irq held", irq, 1'b1);
      bus_write(8'h20, 8'h00);
      peek(8'h20, rd); check("R10 zero write keeps bit", rd, 8'h04);
      bus_write(8'h20, 8'h04);
      peek(8'h20, rd); check("R10 one write clears", rd, 8'h00);
      check("R9 irq drops after clear", irq, 1'b0);

      // R7 falling edge on pin 9 in high group bit 2
      bus_write(8'h19, 8'h02);
      bus_write(8'h25, 8'h3B);
      @(negedge clk); pad_in[9] = 1'b1;
      wait_edges(4);
      peek(8'h21, rd); check("R6 rising ignored for fall select", rd, 8'h00);
      @(negedge clk); pad_in[9] = 1'b0;
      wait_edges(3);
      peek(8'h21, rd); check("R7 pin 9 in status1 bit 2", rd, 8'h04);
      peek(8'h20, rd); check("R7 status0 untouched", rd, 8'h00);
      check("R9 irq from high group", irq, 1'b1);

      // R6 both edges on pin 12, status1 bit 5
      bus_write(8'h1C, 8'h06);
      @(negedge clk); pad_in[12] = 1'b1;
      wait_edges(3);
      peek(8'h21, rd); check("R6 both select rise", rd, 8'h24);
      bus_write(8'h21, 8'h24);
      peek(8'h21, rd); check("R10 clear two bits", rd, 8'h00);

      // R11 clear landing on the capture edge
      @(negedge clk); pad_in[12] = 1'b0;
      wait_edges(3);
      peek(8'h21, rd); check("R6 both select fall", rd, 8'h20);
      @(negedge clk); pad_in[12] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_addr = 8'h21; bus_wdata = 8'h20; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
      peek(8'h21, rd); check("R11 set wins over clear", rd, 8'h20);
      bus_write(8'h21, 8'h20);
      peek(8'h21, rd); check("R10 later clear", rd, 8'h00);
      check("R9 irq low at end", irq, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule